// File: doc/BRIEF.md
# Configurable Radio Packet Framer

This block turns one radio packet, held as bytes in a local buffer, into a serial bit stream. It emits one bit per clock. The fields go out in a fixed order: a preamble, the access address, an optional first header, a length field, an optional second header, the payload, and then the check field. A run-time configuration sets the width of every field. The configuration is captured on the start request, so software may rewrite it while a packet is in flight.

The buffer keeps the first header byte at address 0, the length byte at address 1 and the payload from address 2 onwards. The framer drives the buffer address, and the buffer answers in the same cycle. The framer reads the length byte while it sends the length field, and that byte sets the payload size. The check value comes from a separate engine. A feed flag tells that engine which bits it must cover. A take flag asks it for one check bit per cycle, and the framer sends that bit as it is received. Single-cycle strobes mark the end of the address, the end of the payload and the end of the packet.

Top module: `pkt_framer`

## Requirements
- R1: The preamble is 8 bits when `cfg_pre16` is 0 and 16 bits when it is 1. Its bits alternate, and the first preamble bit is the inverse of the first address bit sent.
- R2: The access address is the word {`cfg_prefix`, the top N bytes of `cfg_base`}, where N is `cfg_base_len` clamped to the range 2 to 4. It is sent as one field of 8*(N+1) bits.
- R3: When `cfg_msb_first` is 0, every field goes out least significant bit first: the address word, the first header byte, the length field and each payload byte. When it is 1, every field goes out most significant bit first.
- R4: The first header is buffer byte 0 (8 bits) and is sent only when `cfg_s0_on` is 1. The length field is the low `cfg_len_bits` bits (0 to 15) of buffer byte 1 zero-extended to 16 bits. The second header is `cfg_s1_bits` zero bits. A field of width 0 is skipped.
- R5: The payload byte count is min(L + `cfg_stat_len`, `cfg_max_len`). L is buffer byte 1 masked to its low `cfg_len_bits` bits, or the whole byte when that width is 8 or more. Payload byte i is read from buffer address 2+i.
- R6: The check field is 8*`cfg_crc_bytes` bits. During those bits `crc_take` is high and `bit_data` equals `crc_bit`. `crc_feed` is high exactly during the header, length and payload bits, and it is never high together with `crc_take`.
- R7: `addr_end` is high for exactly one cycle, the cycle right after the last address bit.
- R8: `payload_end` is high for exactly one cycle, the cycle right after the last payload bit. It stays low for a packet with no payload.
- R9: The first preamble bit appears in the cycle after `start` is sampled while idle. Bits follow with no gaps. `busy` and `bit_valid` are high for exactly the bit cycles. `done` is high for one cycle, the cycle after the last bit, and in that cycle `busy` is low.
- R10: A `start` that arrives while busy is ignored. Changes on the configuration ports during a packet have no effect on that packet.
- R11: While reset is held, `bit_valid`, `busy`, `done`, `addr_end` and `payload_end` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin framing one packet (taken only while idle) |
| cfg_pre16 | input | 1 | Preamble length select: 0 gives 8 bits, 1 gives 16 bits |
| cfg_base_len | input | 3 | Base address bytes, clamped to 2..4 |
| cfg_s0_on | input | 1 | Send buffer byte 0 as the first header |
| cfg_len_bits | input | 4 | Width of the length field in bits |
| cfg_s1_bits | input | 4 | Width of the zero-filled second header in bits |
| cfg_stat_len | input | 8 | Bytes added to the length value |
| cfg_max_len | input | 8 | Upper bound on payload bytes |
| cfg_msb_first | input | 1 | Bit order: 0 least significant first, 1 most significant first |
| cfg_crc_bytes | input | 2 | Check field length in bytes (0..3) |
| cfg_prefix | input | 8 | Address prefix byte (most significant address byte) |
| cfg_base | input | 32 | Base address, top bytes used |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_data | input | 8 | Buffer byte at `buf_addr`, same cycle |
| crc_bit | input | 1 | Next check bit from the check engine |
| bit_valid | output | 1 | A bit is on `bit_data` this cycle |
| bit_data | output | 1 | Serial packet bit |
| crc_feed | output | 1 | Current bit is covered by the check value |
| crc_take | output | 1 | Current bit is a check bit taken from `crc_bit` |
| addr_end | output | 1 | Pulse after the last address bit |
| payload_end | output | 1 | Pulse after the last payload bit |
| done | output | 1 | Pulse after the last bit of the packet |
| busy | output | 1 | A packet is being framed |

## Verification
The bench builds the framer with its default buffer address width of 9 bits and the 12-bit field counter from the package. With these sizes a full 255-byte payload could be addressed, but the bench keeps payloads to a few bytes so that it can sweep the run-time settings instead. It crosses both preamble lengths, base lengths below, inside and above the clamp range, the first header on and off, length widths of 0, 3, 8 and 11 bits, second headers of 0 and 5 bits, both bit orders, and check fields of 0 and 3 bytes. The length byte, static length and maximum vary from packet to packet, so the cap is hit in some packets and missed in others, and some packets have an empty payload. Every other packet gets a second start pulse in mid-flight, and every packet has its configuration scrambled right after the start.

// File: rtl/pkt_frm_pkg.sv
package pkt_frm_pkg;

    localparam int LEN_W   = 12;
    localparam int NUM_FLD = 8;
    localparam int AWORD_W = 40;

    typedef enum logic [2:0] {
        FLD_IDLE = 3'd0,
        FLD_PRE  = 3'd1,
        FLD_ADDR = 3'd2,
        FLD_HDR0 = 3'd3,
        FLD_LEN  = 3'd4,
        FLD_HDR1 = 3'd5,
        FLD_PAY  = 3'd6,
        FLD_CRC  = 3'd7
    } fld_e;

    typedef struct packed {
        logic               pre16;
        logic [2:0]         base_bytes;
        logic               hdr0_on;
        logic [3:0]         len_bits;
        logic [3:0]         hdr1_bits;
        logic [7:0]         stat_len;
        logic [7:0]         max_len;
        logic               msb_first;
        logic [1:0]         crc_bytes;
        logic [AWORD_W-1:0] addr_word;
    } frm_cfg_t;

    function automatic logic [2:0] base_clamp(input logic [2:0] raw);
        if (raw < 3'd2) return 3'd2;
        if (raw > 3'd4) return 3'd4;
        return raw;
    endfunction

    function automatic logic [AWORD_W-1:0] addr_word_of(
        input logic [7:0]  prefix,
        input logic [31:0] base,
        input logic [2:0]  nbytes
    );
        case (nbytes)
            3'd2:    return {16'h0000, prefix, base[31:16]};
            3'd3:    return {8'h00, prefix, base[31:8]};
            default: return {prefix, base};
        endcase
    endfunction

    function automatic logic [7:0] pay_bytes(
        input logic [7:0] raw,
        input logic [3:0] lbits,
        input logic [7:0] stat,
        input logic [7:0] maxl
    );
        logic [7:0] masked;
        logic [8:0] sum;
        masked = (lbits >= 4'd8) ? raw : (raw & ((8'd1 << lbits) - 8'd1));
        sum    = {1'b0, masked} + {1'b0, stat};
        return (sum > {1'b0, maxl}) ? maxl : sum[7:0];
    endfunction

    function automatic logic pick_bit(
        input logic [15:0] val,
        input logic [3:0]  width,
        input logic [3:0]  k,
        input logic        msb
    );
        logic [3:0] idx;
        idx = msb ? (width - 4'd1 - k) : k;
        return val[idx];
    endfunction

endpackage

// File: rtl/pkt_frm_seq.sv
module pkt_frm_seq
    import pkt_frm_pkg::*;
#(
    parameter int NF = NUM_FLD,
    parameter int LW = LEN_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [NF-1:0][LW-1:0] lens,
    output fld_e                  fld,
    output logic [LW-1:0]         cnt,
    output logic                  last_bit,
    output logic                  pkt_end
);

    logic [LW-1:0] cur_len;
    fld_e          nxt;

    always_comb begin
        cur_len  = lens[fld];
        last_bit = (fld != FLD_IDLE) && (cnt == cur_len - LW'(1));
        nxt      = FLD_IDLE;
        for (int i = NF - 1; i > 0; i--) begin
            if (i > int'(fld) && lens[i] != '0) begin
                nxt = fld_e'(i[2:0]);
            end
        end
        pkt_end = last_bit && (nxt == FLD_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fld <= FLD_IDLE;
            cnt <= '0;
        end else if (fld == FLD_IDLE) begin
            if (start) begin
                fld <= FLD_PRE;
            end
            cnt <= '0;
        end else if (last_bit) begin
            fld <= nxt;
            cnt <= '0;
        end else begin
            cnt <= cnt + LW'(1);
        end
    end

endmodule

// File: rtl/pkt_frm_paylen.sv
module pkt_frm_paylen
    import pkt_frm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       in_len,
    input  logic [7:0] init_stat,
    input  logic [7:0] init_max,
    input  logic [7:0] stat,
    input  logic [7:0] max_l,
    input  logic [3:0] len_bits,
    input  logic [7:0] len_byte,
    output logic [7:0] pay_cur
);

    logic [7:0] pay_q;
    logic [7:0] calc;

    always_comb begin
        calc    = pay_bytes(len_byte, len_bits, stat, max_l);
        pay_cur = in_len ? calc : pay_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pay_q <= '0;
        end else if (load) begin
            pay_q <= pay_bytes(8'h00, 4'd0, init_stat, init_max);
        end else if (in_len) begin
            pay_q <= calc;
        end
    end

endmodule

// File: rtl/pkt_frm_bitmux.sv
module pkt_frm_bitmux
    import pkt_frm_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int LW     = LEN_W
) (
    input  fld_e               fld,
    input  logic [LW-1:0]      cnt,
    input  logic               msb,
    input  logic [2:0]         base_bytes,
    input  logic [3:0]         len_bits,
    input  logic [AWORD_W-1:0] addr_word,
    input  logic [7:0]         buf_data,
    input  logic               crc_bit,
    output logic               bit_o,
    output logic [ADDR_W-1:0]  buf_addr,
    output logic               feed,
    output logic               take
);

    logic [5:0]  aw;
    logic [5:0]  aidx;
    logic        a0;
    logic [15:0] bval;

    always_comb begin
        aw   = {base_bytes, 3'b000} + 6'd8;
        aidx = msb ? (aw - 6'd1 - cnt[5:0]) : cnt[5:0];
        a0   = msb ? addr_word[aw - 6'd1] : addr_word[0];
        bval = {8'h00, buf_data};

        case (fld)
            FLD_PRE:  bit_o = a0 ^ ~cnt[0];
            FLD_ADDR: bit_o = addr_word[aidx];
            FLD_HDR0: bit_o = pick_bit(bval, 4'd8, cnt[3:0], msb);
            FLD_LEN:  bit_o = pick_bit(bval, len_bits, cnt[3:0], msb);
            FLD_PAY:  bit_o = pick_bit(bval, 4'd8, {1'b0, cnt[2:0]}, msb);
            FLD_CRC:  bit_o = crc_bit;
            default:  bit_o = 1'b0;
        endcase

        case (fld)
            FLD_LEN: buf_addr = ADDR_W'(1);
            FLD_PAY: buf_addr = ADDR_W'(2) + ADDR_W'(cnt[LW-1:3]);
            default: buf_addr = '0;
        endcase

        feed = (fld == FLD_HDR0) || (fld == FLD_LEN) ||
               (fld == FLD_HDR1) || (fld == FLD_PAY);
        take = (fld == FLD_CRC);
    end

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
    import pkt_frm_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cfg_pre16,
    input  logic [2:0]        cfg_base_len,
    input  logic              cfg_s0_on,
    input  logic [3:0]        cfg_len_bits,
    input  logic [3:0]        cfg_s1_bits,
    input  logic [7:0]        cfg_stat_len,
    input  logic [7:0]        cfg_max_len,
    input  logic              cfg_msb_first,
    input  logic [1:0]        cfg_crc_bytes,
    input  logic [7:0]        cfg_prefix,
    input  logic [31:0]       cfg_base,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_data,
    input  logic              crc_bit,
    output logic              bit_valid,
    output logic              bit_data,
    output logic              crc_feed,
    output logic              crc_take,
    output logic              addr_end,
    output logic              payload_end,
    output logic              done,
    output logic              busy
);

    frm_cfg_t                      cfg_d;
    frm_cfg_t                      cfg_q;
    fld_e                          fld;
    logic [LEN_W-1:0]              cnt;
    logic                          last_bit;
    logic                          pkt_end;
    logic                          start_acc;
    logic [7:0]                    pay_cur;
    logic [NUM_FLD-1:0][LEN_W-1:0] lens;
    logic                          addr_end_q;
    logic                          pay_end_q;
    logic                          done_q;

    always_comb begin
        cfg_d.pre16      = cfg_pre16;
        cfg_d.base_bytes = base_clamp(cfg_base_len);
        cfg_d.hdr0_on    = cfg_s0_on;
        cfg_d.len_bits   = cfg_len_bits;
        cfg_d.hdr1_bits  = cfg_s1_bits;
        cfg_d.stat_len   = cfg_stat_len;
        cfg_d.max_len    = cfg_max_len;
        cfg_d.msb_first  = cfg_msb_first;
        cfg_d.crc_bytes  = cfg_crc_bytes;
        cfg_d.addr_word  = addr_word_of(cfg_prefix, cfg_base, base_clamp(cfg_base_len));
    end

    assign start_acc = start && (fld == FLD_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (start_acc) begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        lens           = '0;
        lens[FLD_PRE]  = cfg_q.pre16 ? LEN_W'(16) : LEN_W'(8);
        lens[FLD_ADDR] = LEN_W'({cfg_q.base_bytes, 3'b000}) + LEN_W'(8);
        lens[FLD_HDR0] = cfg_q.hdr0_on ? LEN_W'(8) : '0;
        lens[FLD_LEN]  = LEN_W'(cfg_q.len_bits);
        lens[FLD_HDR1] = LEN_W'(cfg_q.hdr1_bits);
        lens[FLD_PAY]  = LEN_W'({pay_cur, 3'b000});
        lens[FLD_CRC]  = LEN_W'({cfg_q.crc_bytes, 3'b000});
    end

    pkt_frm_seq #(
        .NF (NUM_FLD),
        .LW (LEN_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_acc),
        .lens     (lens),
        .fld      (fld),
        .cnt      (cnt),
        .last_bit (last_bit),
        .pkt_end  (pkt_end)
    );

    pkt_frm_paylen u_paylen (
        .clk       (clk),
        .rst       (rst),
        .load      (start_acc),
        .in_len    (fld == FLD_LEN),
        .init_stat (cfg_stat_len),
        .init_max  (cfg_max_len),
        .stat      (cfg_q.stat_len),
        .max_l     (cfg_q.max_len),
        .len_bits  (cfg_q.len_bits),
        .len_byte  (buf_data),
        .pay_cur   (pay_cur)
    );

    pkt_frm_bitmux #(
        .ADDR_W (ADDR_W),
        .LW     (LEN_W)
    ) u_bitmux (
        .fld        (fld),
        .cnt        (cnt),
        .msb        (cfg_q.msb_first),
        .base_bytes (cfg_q.base_bytes),
        .len_bits   (cfg_q.len_bits),
        .addr_word  (cfg_q.addr_word),
        .buf_data   (buf_data),
        .crc_bit    (crc_bit),
        .bit_o      (bit_data),
        .buf_addr   (buf_addr),
        .feed       (crc_feed),
        .take       (crc_take)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_end_q <= 1'b0;
            pay_end_q  <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            addr_end_q <= last_bit && (fld == FLD_ADDR);
            pay_end_q  <= last_bit && (fld == FLD_PAY);
            done_q     <= pkt_end;
        end
    end

    assign bit_valid   = (fld != FLD_IDLE);
    assign busy        = (fld != FLD_IDLE);
    assign addr_end    = addr_end_q;
    assign payload_end = pay_end_q;
    assign done        = done_q;

endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic bit_valid,
    input logic busy,
    input logic done,
    input logic addr_end,
    input logic payload_end,
    input logic crc_feed,
    input logic crc_take
);

    // R9
    first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bit_valid) |-> ($past(start) && !$past(busy)));

    // R9
    done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(bit_valid) && !bit_valid && !busy));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R7
    addr_end_chk: assert property (@(posedge clk) disable iff (rst)
        addr_end |-> ($past(busy) && !$past(addr_end)));

    // R8
    strobe_sep_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({addr_end, payload_end}));

    // R8
    pay_end_chk: assert property (@(posedge clk) disable iff (rst)
        payload_end |-> ($past(crc_feed) && !$past(payload_end)));

    // R6
    region_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({crc_feed, crc_take}));

    // R6
    region_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (crc_feed || crc_take) |-> bit_valid);

endmodule

bind pkt_framer pkt_framer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .bit_valid   (bit_valid),
    .busy        (busy),
    .done        (done),
    .addr_end    (addr_end),
    .payload_end (payload_end),
    .crc_feed    (crc_feed),
    .crc_take    (crc_take)
);

// File: tb/pkt_framer_tb.sv
`timescale 1ns/1ps
module pkt_framer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        cfg_pre16;
    logic [2:0]  cfg_base_len;
    logic        cfg_s0_on;
    logic [3:0]  cfg_len_bits;
    logic [3:0]  cfg_s1_bits;
    logic [7:0]  cfg_stat_len;
    logic [7:0]  cfg_max_len;
    logic        cfg_msb_first;
    logic [1:0]  cfg_crc_bytes;
    logic [7:0]  cfg_prefix;
    logic [31:0] cfg_base;
    logic [8:0]  buf_addr;
    logic [7:0]  buf_data;
    logic        crc_bit;
    logic        bit_valid, bit_data, crc_feed, crc_take;
    logic        addr_end, payload_end, done, busy;

    logic [7:0]  mem [0:511];
    logic [31:0] crc_pat;
    logic [4:0]  crc_idx;

    logic        e_bit [0:511];
    int          e_reg [0:511];
    logic        g_bit [0:511];
    logic        g_feed [0:511];
    logic        g_take [0:511];

    int n_chk = 0;
    int n_err = 0;
    bit all_done = 0;

    always #4 clk = ~clk;

    assign buf_data = mem[buf_addr];
    assign crc_bit  = crc_pat[crc_idx];

    always_ff @(posedge clk) begin
        if (!busy) crc_idx <= '0;
        else if (crc_take) crc_idx <= crc_idx + 5'd1;
    end

    pkt_framer #(.ADDR_W(9)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_pre16(cfg_pre16), .cfg_base_len(cfg_base_len), .cfg_s0_on(cfg_s0_on),
        .cfg_len_bits(cfg_len_bits), .cfg_s1_bits(cfg_s1_bits),
        .cfg_stat_len(cfg_stat_len), .cfg_max_len(cfg_max_len),
        .cfg_msb_first(cfg_msb_first), .cfg_crc_bytes(cfg_crc_bytes),
        .cfg_prefix(cfg_prefix), .cfg_base(cfg_base),
        .buf_addr(buf_addr), .buf_data(buf_data), .crc_bit(crc_bit),
        .bit_valid(bit_valid), .bit_data(bit_data), .crc_feed(crc_feed),
        .crc_take(crc_take), .addr_end(addr_end), .payload_end(payload_end),
        .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_pkt(input int pk, input bit pr, input int bl, input bit so,
                           input int lf, input int s1, input bit mf, input int cb);
        int nb, aw, plen, n, total, pay, m, sum, p_addr, p_pay;
        int got_n, cyc, ae_n, ae_pos, pe_n, pe_pos, dn_n, dn_cyc, bz_low, ghost;
        int mis [0:5];
        bit first, fin;
        logic [63:0] av;
        logic [15:0] lv;
        logic [7:0]  byt;

        for (int i = 0; i < 16; i++) mem[i] = 8'((i * 37 + pk * 11 + 5) & 255);
        mem[1]  = 8'((pk * 7 + 3) & 255);
        crc_pat = 32'h00A5C31E ^ 32'(pk * 2654435);

        cfg_pre16     = pr;
        cfg_base_len  = 3'(bl);
        cfg_s0_on     = so;
        cfg_len_bits  = 4'(lf);
        cfg_s1_bits   = 4'(s1);
        cfg_stat_len  = 8'(pk % 3);
        cfg_max_len   = 8'(3 + pk % 5);
        cfg_msb_first = mf;
        cfg_crc_bytes = 2'(cb);
        cfg_prefix    = 8'h8E ^ 8'(pk);
        cfg_base      = 32'h89BED600 ^ 32'(pk * 40503);

        // expected stream, built from the requirements
        nb   = (bl < 2) ? 2 : ((bl > 4) ? 4 : bl);
        aw   = 8 * (nb + 1);
        av   = (64'(cfg_prefix) << (8 * nb)) | (64'(cfg_base) >> (8 * (4 - nb)));
        first = mf ? av[aw - 1] : av[0];
        plen = pr ? 16 : 8;
        n = 0;
        for (int k = 0; k < plen; k++) begin
            e_bit[n] = first ^ (k % 2 == 0); e_reg[n] = 0; n++;
        end
        for (int i = 0; i < aw; i++) begin
            e_bit[n] = mf ? av[aw - 1 - i] : av[i]; e_reg[n] = 1; n++;
        end
        p_addr = n;
        if (so) begin
            byt = mem[0];
            for (int i = 0; i < 8; i++) begin
                e_bit[n] = mf ? byt[7 - i] : byt[i]; e_reg[n] = 2; n++;
            end
        end
        lv = {8'h00, mem[1]};
        for (int i = 0; i < lf; i++) begin
            e_bit[n] = mf ? lv[lf - 1 - i] : lv[i]; e_reg[n] = 2; n++;
        end
        for (int i = 0; i < s1; i++) begin
            e_bit[n] = 1'b0; e_reg[n] = 2; n++;
        end
        m   = (lf >= 8) ? int'(mem[1]) : (int'(mem[1]) & ((1 << lf) - 1));
        sum = m + (pk % 3);
        pay = (sum > 3 + pk % 5) ? (3 + pk % 5) : sum;
        for (int b = 0; b < pay; b++) begin
            byt = mem[2 + b];
            for (int i = 0; i < 8; i++) begin
                e_bit[n] = mf ? byt[7 - i] : byt[i]; e_reg[n] = 3; n++;
            end
        end
        p_pay = n;
        for (int i = 0; i < 8 * cb; i++) begin
            e_bit[n] = crc_pat[i]; e_reg[n] = 4; n++;
        end
        total = n;

        got_n = 0; ae_n = 0; ae_pos = -1; pe_n = 0; pe_pos = -1;
        dn_n = 0; dn_cyc = -1; bz_low = 0; ghost = 0;
        for (int i = 0; i < 6; i++) mis[i] = 0;

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        // R10: scramble configuration while the packet runs
        cfg_pre16 = ~pr; cfg_base_len = 3'(7 - bl); cfg_s0_on = ~so;
        cfg_len_bits = ~4'(lf); cfg_s1_bits = ~4'(s1); cfg_stat_len = 8'hF0;
        cfg_max_len = 8'hFF; cfg_msb_first = ~mf; cfg_crc_bytes = ~2'(cb);
        cfg_prefix = ~cfg_prefix; cfg_base = ~cfg_base;
        cyc = 1; fin = 0;
        while (!fin) begin
            if (addr_end) begin ae_n++; ae_pos = got_n; end
            if (payload_end) begin pe_n++; pe_pos = got_n; end
            if (done) begin dn_n++; dn_cyc = cyc; fin = 1; end
            else if (!busy) bz_low++;
            if (bit_valid) begin
                if (got_n < 512) begin
                    g_bit[got_n] = bit_data; g_feed[got_n] = crc_feed; g_take[got_n] = crc_take;
                end
                got_n++;
            end
            start = (pk % 2 == 1) && (cyc == 10);
            if (!fin) begin
                @(negedge clk);
                cyc++;
                if (cyc > 2000) begin
                    fin = 1;
                    check(0, "R9 packet never finished", cyc, total + 1);
                end
            end
        end
        start = 1'b0;
        repeat (3) begin
            @(negedge clk);
            if (bit_valid || busy) ghost++;
        end

        for (int i = 0; i < total; i++) begin
            if (i < got_n && i < 512) begin
                if (g_bit[i] !== e_bit[i]) mis[e_reg[i]]++;
                if (g_feed[i] !== (e_reg[i] == 2 || e_reg[i] == 3) ||
                    g_take[i] !== (e_reg[i] == 4)) mis[5]++;
            end
        end

        check(got_n == total, "R9 bit count", got_n, total);
        check(dn_n == 1 && dn_cyc == total + 1, "R9 done timing", dn_cyc, total + 1);
        check(mis[0] == 0, "R1 preamble bits wrong", mis[0], 0);
        check(mis[1] == 0, "R2 R3 address bits wrong", mis[1], 0);
        check(mis[2] == 0, "R4 R3 header bits wrong", mis[2], 0);
        check(mis[3] == 0, "R5 R3 payload bits wrong", mis[3], 0);
        check(mis[4] == 0, "R6 check bits wrong", mis[4], 0);
        check(mis[5] == 0, "R6 feed/take flags wrong", mis[5], 0);
        check(ae_n == 1 && ae_pos == p_addr, "R7 addr_end position", ae_pos, p_addr);
        if (pay > 0)
            check(pe_n == 1 && pe_pos == p_pay, "R8 payload_end position", pe_pos, p_pay);
        else
            check(pe_n == 0, "R8 payload_end on empty payload", pe_n, 0);
        check(bz_low == 0 && ghost == 0, "R10 busy gap or restart", bz_low + ghost, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!all_done) begin
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int pk;
        int lf_tab [0:3];
        lf_tab[0] = 0; lf_tab[1] = 3; lf_tab[2] = 8; lf_tab[3] = 11;
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        crc_pat = '0;
        rst = 1'b1; start = 1'b0;
        cfg_pre16 = 0; cfg_base_len = 3'd3; cfg_s0_on = 0; cfg_len_bits = 4'd8;
        cfg_s1_bits = 4'd0; cfg_stat_len = 8'd0; cfg_max_len = 8'd255;
        cfg_msb_first = 0; cfg_crc_bytes = 2'd3; cfg_prefix = 8'h8E; cfg_base = 32'h89BED600;
        repeat (4) @(negedge clk);
        // R11: reset state
        check(!bit_valid && !busy && !done && !addr_end && !payload_end,
              "R11 outputs during reset",
              int'({bit_valid, busy, done, addr_end, payload_end}), 0);
        start = 1'b1;
        @(negedge clk);
        check(!busy && !bit_valid, "R11 start ignored in reset", int'(busy), 0);
        start = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        pk = 0;
        for (int p = 0; p < 2; p++)
            for (int b = 0; b < 3; b++)
                for (int s = 0; s < 2; s++)
                    for (int l = 0; l < 4; l++)
                        for (int h = 0; h < 2; h++)
                            for (int o = 0; o < 2; o++)
                                for (int c = 0; c < 2; c++) begin
                                    run_pkt(pk, p[0], 1 + 2 * b, s[0], lf_tab[l],
                                            5 * h, o[0], 3 * c);
                                    pk++;
                                end
        all_done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule